// File: doc/BRIEF.md
# Cascadable Pulse Accumulator Pair

The block holds two 8-bit counters, each fed by its own pulse input. It adds one to a counter for each selected edge on that input, and the active edge can be set to rising or falling for each input. Each input passes through a two-flop synchroniser, and an edge detector works on the synchronised value. A control bit joins the two counters into one 16-bit accumulator. The lower byte then takes its events from pulse input 0, and the carry out of the lower byte steps the upper byte in the same clock cycle.

A single overflow flag records a wrap of the upper counter, or of the full 16-bit value when the counters are joined. Software clears the flag by writing a one to it. A fast-clear mode instead clears it on any access to a count register. An interrupt request follows the flag whenever the interrupt enable bit is set. Counting depends only on the block's own enable bits. No other timer enable affects it.

Software reaches the block through a four-entry register file. Writes are strobed, and the read data is combinational from the address. Both count bytes can be read and loaded.

Top module: `pa_pair`

## Requirements
- R1: While reset is asserted, every register (address 0 lower count, 1 upper count, 2 control, 3 flag) reads 0x00 and `irq` is 0.
- R2: With control bit 4 (join) at 0, the lower counter (address 0) counts events on `pulse_in[0]` when control bit 0 is 1. The upper counter (address 1) counts events on `pulse_in[1]` when control bit 1 is 1. A counter whose enable bit is 0 holds its value.
- R3: Control bit 2 selects the active edge for `pulse_in[0]` and control bit 3 selects it for `pulse_in[1]` (0 = rising, 1 = falling). The other edge is not counted. A pin change driven before clock edge k shows in the count after clock edge k+2.
- R4: With control bit 4 at 1, address 1 holds the high byte and address 0 the low byte of a 16-bit count. Only `pulse_in[0]` is counted, using the edge chosen by bit 2. A lower-byte wrap from 0xFF to 0x00 increments the upper byte in the same cycle. Control bits 0 and 1, and `pulse_in[1]`, have no effect.
- R5: The overflow flag is bit 1 of address 3, and the other bits of address 3 read 0. It sets when the upper counter counts from 0xFF to 0x00 while the counters are separate, or when the 16-bit count wraps from 0xFFFF to 0x0000 while they are joined. A wrap of the lower byte alone, while the counters are separate, does not set it.
- R6: A write to address 3 with data bit 1 at 1 clears the flag. A write to address 3 with bit 1 at 0 leaves the flag unchanged.
- R7: With control bit 5 at 1, any read strobe or write to address 0 or 1 clears the flag. With bit 5 at 0, such an access leaves the flag unchanged.
- R8: `irq` is 1 exactly while the flag is 1 and control bit 6 (interrupt enable) is 1.
- R9: A count-register write takes priority over a count event on that byte in the same cycle. A new overflow in the same cycle as a flag clear leaves the flag set.
- R10: Address 2 reads back bits 6:0 as written, and bit 7 reads 0. The count registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (its only effect is fast clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pulse_in | input | 2 | Asynchronous pulse inputs, bit 0 lower and bit 1 upper |
| irq | output | 1 | Overflow interrupt request |

## Verification
The counters are driven with whole pulses, with lone rising and lone falling transitions, and with steps timed one cycle apart. These patterns separate rising-edge counting from falling-edge counting and pin down the three-cycle latency. Runs of pulses on the upper input are made with its enable cleared and with the counters joined, to show that the input is ignored there. The counts are preset just below 0xFF and 0xFFFF. This shows a lower-byte wrap, an upper-byte wrap and a 16-bit wrap apart, and shows that the carry lands in the same cycle. Bus accesses are placed in exactly the cycle of a count event, which exposes the write-priority rule and the rule that a new overflow wins over a clear.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NCH     = 2;

  localparam logic [ADDR_W-1:0] A_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] A_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd3;

  localparam int unsigned FLAG_BIT = 1;

  typedef struct packed {
    logic             rsvd;
    logic             irq_en;
    logic             fast_clr;
    logic             join_en;
    logic [NCH-1:0]   fall;
    logic [NCH-1:0]   en;
  } ctrl_t;
endpackage

// File: rtl/pa_rst_sync.sv
module pa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= sh_n;
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/pa_edge_det.sv
module pa_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall,
  output logic ev
);
  localparam int unsigned LEN = SYNC_STAGES + 1;

  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_n;
  logic           cur;
  logic           prev;

  always_comb begin
    chain_n = {chain_q[LEN-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign cur  = chain_q[SYNC_STAGES-1];
  assign prev = chain_q[SYNC_STAGES];

  always_comb begin
    if (fall) ev = prev & ~cur;
    else      ev = cur & ~prev;
  end
endmodule

// File: rtl/pa_count_core.sv
module pa_count_core #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    ev,
  input  logic [1:0]    en,
  input  logic          join_en,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [CW-1:0] ld_data,
  output logic [CW-1:0] lo_q,
  output logic [CW-1:0] hi_q,
  output logic          ovf_set
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic          inc_lo;
  logic          inc_hi;
  logic          carry;
  logic [CW-1:0] lo_n;
  logic [CW-1:0] hi_n;

  always_comb begin
    inc_lo = ev[0] & (join_en | en[0]);
    carry  = join_en & inc_lo & (lo_q == MAXV) & ~ld_lo;
    inc_hi = join_en ? carry : (ev[1] & en[1]);

    if (ld_lo)       lo_n = ld_data;
    else if (inc_lo) lo_n = lo_q + ONE;
    else             lo_n = lo_q;

    if (ld_hi)       hi_n = ld_data;
    else if (inc_hi) hi_n = hi_q + ONE;
    else             hi_n = hi_q;

    ovf_set = inc_hi & (hi_q == MAXV) & ~ld_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/pa_regs.sv
module pa_regs
  import pa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic [BUS_W-1:0]  lo_q,
  input  logic [BUS_W-1:0]  hi_q,
  input  logic              ovf_set,
  output ctrl_t             ctrl,
  output logic              flag_q,
  output logic              ld_lo,
  output logic              ld_hi,
  output logic              irq
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_n;
  logic  flag_n;
  logic  wr_ctrl;
  logic  wr_flag;
  logic  cnt_hit;
  logic  fast_hit;
  logic  clr;

  always_comb begin
    ld_lo    = wr & (addr == A_LO);
    ld_hi    = wr & (addr == A_HI);
    wr_ctrl  = wr & (addr == A_CTRL);
    wr_flag  = wr & (addr == A_FLAG);
    cnt_hit  = (addr == A_LO) | (addr == A_HI);
    fast_hit = ctrl_q.fast_clr & (rd | wr) & cnt_hit;
    clr      = (wr_flag & wdata[FLAG_BIT]) | fast_hit;
    flag_n   = ovf_set | (flag_q & ~clr);

    ctrl_n = ctrl_q;
    if (wr_ctrl) begin
      ctrl_n      = ctrl_t'(wdata);
      ctrl_n.rsvd = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      flag_q <= flag_n;
    end
  end

  always_comb begin
    unique case (addr)
      A_LO:    rdata = lo_q;
      A_HI:    rdata = hi_q;
      A_CTRL:  rdata = ctrl_q;
      default: begin
        rdata           = '0;
        rdata[FLAG_BIT] = flag_q;
      end
    endcase
  end

  assign ctrl = ctrl_q;
  assign irq  = flag_q & ctrl_q.irq_en;
endmodule

// File: rtl/pa_pair.sv
module pa_pair
  import pa_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NCH-1:0]    pulse_in,
  output logic              irq
);
  logic             rst_n_s;
  logic [NCH-1:0]   ev;
  ctrl_t            ctrl;
  logic [BUS_W-1:0] lo_q;
  logic [BUS_W-1:0] hi_q;
  logic             ovf_set;
  logic             flag_q;
  logic             ld_lo;
  logic             ld_hi;

  pa_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pa_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n_s),
      .pin   (pulse_in[g]),
      .fall  (ctrl.fall[g]),
      .ev    (ev[g])
    );
  end

  pa_count_core #(.CW(BUS_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ev      (ev),
    .en      (ctrl.en),
    .join_en (ctrl.join_en),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .ld_data (bus_wdata),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .ovf_set (ovf_set)
  );

  pa_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .ovf_set (ovf_set),
    .ctrl    (ctrl),
    .flag_q  (flag_q),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .irq     (irq)
  );
endmodule

// File: rtl/pa_pair_chk.sv
module pa_pair_chk #(
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic [1:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [CW-1:0] bus_wdata,
  input logic          irq,
  input logic [1:0]    ev,
  input logic [1:0]    en,
  input logic          join_en,
  input logic          fast_clr,
  input logic          irq_en,
  input logic [CW-1:0] lo_q,
  input logic [CW-1:0] hi_q,
  input logic          flag_q,
  input logic          ld_lo,
  input logic          ld_hi
);
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  assert_join_carry_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (join_en && ev[0] && lo_q == MAXV && !ld_lo && !ld_hi)
    |=> (lo_q == '0 && hi_q == CW'($past(hi_q) + 1'b1)));

  assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flag_q) |-> ($past(hi_q) == MAXV));

  assert_upper_hold_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!join_en && !en[1] && !ld_hi) |=> $stable(hi_q));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !irq_en |-> !irq);

  assert_fast_clear_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fast_clr && bus_rd && !bus_wr && bus_addr == 2'd0 && hi_q != MAXV) |=> !flag_q);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == 2'd3 && bus_wdata[1] && hi_q != MAXV) |=> !flag_q);

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ld_lo |=> (lo_q == $past(bus_wdata)));
endmodule

bind pa_pair pa_pair_chk #(.CW(pa_pkg::BUS_W)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .ev        (ev),
  .en        (ctrl.en),
  .join_en   (ctrl.join_en),
  .fast_clr  (ctrl.fast_clr),
  .irq_en    (ctrl.irq_en),
  .lo_q      (lo_q),
  .hi_q      (hi_q),
  .flag_q    (flag_q),
  .ld_lo     (ld_lo),
  .ld_hi     (ld_hi)
);

// File: tb/pa_pair_test.sv
`timescale 1ns/1ps
module pa_pair_test;
  logic       clk;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr;
  logic       rd;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [1:0] pins;
  logic       irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  int cyc = 0;

  pa_pair uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_rd    (rd),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pulse_in  (pins),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference state
  int  m_lo, m_hi, m_ctrl;
  bit  m_flag;
  bit  s1 [2];
  bit  s2 [2];
  bit  s3 [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_ctrl = 0; m_flag = 0;
      for (int i = 0; i < 2; i++) begin s1[i] = 0; s2[i] = 0; s3[i] = 0; end
    end else begin
      bit e [2];
      bit wlo, whi, hit, setf, clrf;
      int t;
      for (int i = 0; i < 2; i++) begin
        if (m_ctrl[2+i]) e[i] = !s2[i] && s3[i];
        else             e[i] = s2[i] && !s3[i];
      end
      wlo  = wr && addr == 0;
      whi  = wr && addr == 1;
      setf = 0;
      if (m_ctrl[4]) begin
        if (e[0] && !wlo) begin
          t = m_lo + 1;
          if (t == 256 && !whi) begin
            if (m_hi == 255) setf = 1;
            m_hi = (m_hi + 1) % 256;
          end
          m_lo = t % 256;
        end
      end else begin
        if (e[0] && m_ctrl[0] && !wlo) m_lo = (m_lo + 1) % 256;
        if (e[1] && m_ctrl[1] && !whi) begin
          if (m_hi == 255) setf = 1;
          m_hi = (m_hi + 1) % 256;
        end
      end
      if (wlo) m_lo = wdata;
      if (whi) m_hi = wdata;
      hit  = m_ctrl[5] && (rd || wr) && addr < 2;
      clrf = (wr && addr == 3 && wdata[1]) || hit;
      if (setf) m_flag = 1;
      else if (clrf) m_flag = 0;
      if (wr && addr == 2) m_ctrl = wdata & 8'h7F;
      for (int i = 0; i < 2; i++) begin s3[i] = s2[i]; s2[i] = s1[i]; s1[i] = pins[i]; end
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return m_lo;
      1: return m_hi;
      2: return m_ctrl;
      default: return m_flag ? 2 : 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(posedge clk) begin
    #2;
    check({cur_req, " rdata"}, int'(rdata), model_rd(int'(addr)));
    check({cur_req, " irq"}, int'(irq), int'(m_flag && m_ctrl[6]));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a);
    @(negedge clk); addr = a; rd = 1'b1; wr = 1'b0;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input string req, input logic [1:0] a, input int exp);
    @(negedge clk); addr = a; wr = 1'b0; rd = 1'b0;
    #1 check(req, int'(rdata), exp);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); pins[ch] = 1'b1;
    idle(4);
    pins[ch] = 1'b0;
    idle(4);
  endtask

  // rising step on ch, with a bus write landing in the cycle it is counted
  task automatic edge_with_write(input int ch, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); pins[ch] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    idle(3); pins[ch] = 1'b0;
    idle(4);
  endtask

  initial begin
    rst_n = 1'b0; addr = 0; wr = 0; rd = 0; wdata = 0; pins = 0;
    idle(2);
    cur_req = "R1";
    for (int a = 0; a < 4; a++) peek("R1 reset value", 2'(a), 0);
    check("R1 irq in reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(6);

    cur_req = "R2";
    bus_wr(2, 8'h03);
    repeat (3) pulse(0);
    repeat (2) pulse(1);
    peek("R2 lower count", 0, 3);
    peek("R2 upper count", 1, 2);

    cur_req = "R3";
    @(negedge clk); pins[0] = 1'b1; addr = 0;
    peek("R3 latency edge k", 0, 3);
    peek("R3 latency edge k+1", 0, 3);
    peek("R3 latency edge k+2", 0, 4);
    idle(2); pins[0] = 1'b0; idle(4);
    bus_wr(2, 8'h07);
    @(negedge clk); pins[0] = 1'b1; idle(5);
    peek("R3 rising ignored in falling mode", 0, 4);
    pins[0] = 1'b0; idle(5);
    peek("R3 falling counted", 0, 5);

    cur_req = "R2";
    bus_wr(2, 8'h01);
    repeat (2) pulse(1);
    peek("R2 disabled upper holds", 1, 2);

    cur_req = "R5";
    bus_wr(2, 8'h03);
    bus_wr(1, 8'hFE);
    bus_wr(0, 8'hFF);
    pulse(0);
    peek("R5 lower wrap value", 0, 0);
    peek("R5 lower wrap no flag", 3, 0);
    pulse(1);
    peek("R5 no flag at FF", 3, 0);
    pulse(1);
    peek("R5 upper wrap value", 1, 0);
    peek("R5 upper wrap flag", 3, 2);

    cur_req = "R6";
    bus_wr(3, 8'hFD);
    peek("R6 write zero keeps flag", 3, 2);
    bus_wr(3, 8'h02);
    peek("R6 write one clears", 3, 0);

    cur_req = "R8";
    bus_wr(1, 8'hFF);
    pulse(1);
    check("R8 irq gated off", int'(irq), 0);
    bus_wr(2, 8'h43);
    #1 check("R8 irq raised", int'(irq), 1);
    bus_wr(3, 8'h02);
    #1 check("R8 irq drops with flag", int'(irq), 0);

    cur_req = "R4";
    bus_wr(2, 8'h10);
    bus_wr(0, 8'hFF);
    bus_wr(1, 8'h12);
    pulse(0);
    peek("R4 carry low", 0, 0);
    peek("R4 carry high", 1, 8'h13);
    repeat (2) pulse(1);
    peek("R4 upper input ignored", 1, 8'h13);
    peek("R4 lower unchanged by upper input", 0, 0);
    bus_wr(0, 8'hFF);
    bus_wr(1, 8'hFF);
    pulse(0);
    peek("R5 16-bit wrap flag", 3, 2);
    peek("R4 16-bit wrap high", 1, 0);

    cur_req = "R7";
    bus_rd(0);
    peek("R7 read without fast clear", 3, 2);
    bus_wr(2, 8'h30);
    bus_rd(1);
    peek("R7 read clears", 3, 0);
    bus_wr(0, 8'hFF);
    bus_wr(1, 8'hFF);
    pulse(0);
    peek("R7 flag set again", 3, 2);
    bus_wr(0, 8'h55);
    peek("R7 write clears", 3, 0);
    peek("R7 write value", 0, 8'h55);

    cur_req = "R9";
    bus_wr(2, 8'h03);
    bus_wr(0, 8'h10);
    edge_with_write(0, 0, 8'h80);
    peek("R9 write beats count", 0, 8'h80);
    bus_wr(1, 8'hFF);
    edge_with_write(1, 3, 8'h02);
    peek("R9 set beats clear", 3, 2);
    peek("R9 upper wrapped", 1, 0);

    cur_req = "R10";
    bus_wr(2, 8'hFF);
    peek("R10 control readback", 2, 8'h7F);
    bus_wr(2, 8'h00);
    bus_wr(1, 8'hA5);
    peek("R10 upper readback", 1, 8'hA5);
    idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule